// File: doc/BRIEF.md
# Register-Driven I2C Byte Master

This block is a single-master I2C engine that software steers one byte at a time through three registers. The registers are a control word, a pair of completion flags and a one-byte data buffer. Software places an address byte or a data byte in the buffer and sets the control bits that shape the next transfer: start, stop, negative-acknowledge on receive, and an arbitration-loss interrupt enable. It then sets the transfer trigger bit. The engine performs the byte and clears the trigger when the byte ends. It then raises a transmit-empty or receive-full flag, and the interrupt line follows either flag.

Since a bus that has no stop pending stays owned between bytes, software can chain phases without releasing the bus. A typical chain is an address write, data writes, a repeated start with a read address, and reads ending in a negative-acknowledge and a stop. SCL timing comes from a quarter-bit divider parameter. Both lines are open-drain, so each is modelled as a pull-low output, and SDA also has a sense input.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, the control word (bit 0 start, bit 1 stop, bit 2 nak-on-receive, bit 3 trigger, bit 4 arbitration enable) reads 0. Both flags, busy and irq read 0, and neither line is pulled low.
- R2: When the trigger is set together with start, SDA falls while SCL is high. The buffer byte then goes out MSB first, busy rises, and the direction status takes bit 0 of that byte (1 = read).
- R3: At the end of a transmitted byte the transmit-empty flag and irq rise and the trigger bit clears. The ack status holds the SDA level the slave gave in the ninth clock (1 = NAK).
- R4: A status write clears transmit-empty through bit 0 and receive-full through bit 1 where the written bit is 1. A written 0 leaves its flag unchanged.
- R5: A trigger with start and stop both clear sends the buffer byte as data. SCL is then held low and busy stays 1, with no stop condition.
- R6: Start with the trigger while the bus is held produces a repeated start (SDA falls while SCL is high) with no stop before it, and the new address byte is sent after it.
- R7: A received byte with nak-on-receive clear is acknowledged by the master pulling SDA low in the ninth clock. Receive-full then rises, the trigger clears, and the buffer holds the byte.
- R8: A received byte with nak-on-receive and stop set is answered with NAK, and the ack status reads 1. Receive-full rises while busy is still 1. A stop condition follows, after which busy falls and both lines are released.
- R9: Within a byte, SDA changes only while SCL is low. The only SDA edges while SCL is high are the start, repeated-start and stop conditions.
- R10: If the engine sets a flag in the same cycle that software writes 1 to clear it, the set wins.
- R11: The arbitration enable bit is stored and read back as written, and it does not alter any transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 5 | Control word write value |
| stat_we | input | 1 | Flag clear strobe |
| stat_wdata | input | 2 | Write-1-to-clear mask: bit 0 transmit-empty, bit 1 receive-full |
| buf_we | input | 1 | Data buffer write strobe |
| buf_wdata | input | 8 | Data buffer write value |
| ctrl_q | output | 5 | Control word readback |
| buf_q | output | 8 | Data buffer readback |
| tx_empty | output | 1 | Transmit-empty flag |
| rx_full | output | 1 | Receive-full flag |
| busy | output | 1 | Bus owned, from start until stop completes |
| dir_rd | output | 1 | Direction of the last address byte (1 = read) |
| ack_stat | output | 1 | Ninth-bit level of the last byte (1 = NAK) |
| irq | output | 1 | Interrupt, high while either flag is set |
| scl_low | output | 1 | Pull SCL low |
| sda_low | output | 1 | Pull SDA low |
| sda_in | input | 1 | Sensed SDA level |

## Verification
The one collision that matters is a flag being set by the engine at the end of a byte in the same cycle that software writes 1 to clear it. The bench provokes it by holding the clear strobe for transmit-empty asserted through a whole data byte, so the completion cycle must coincide with a clear. It judges that the set won by seeing the flag high at the next sample and still high once the strobe is dropped. If the clear had won, the flag would never have appeared and the wait would time out.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int CTRL_W    = 5;
  localparam int CB_START  = 0;
  localparam int CB_STOP   = 1;
  localparam int CB_ACKNAK = 2;
  localparam int CB_TB     = 3;
  localparam int CB_ALIE   = 4;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_START,
    ENG_BYTE,
    ENG_STOP,
    ENG_HOLD
  } eng_state_e;
endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
  parameter int QDIV = 312
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic qtick
);
  localparam int CW = $clog2(QDIV + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last  = (cnt_q == CW'(QDIV - 1));
  assign qtick = run && last;

  always_comb begin
    if (!run || last) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int QDIV = 312
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       want_start,
  input  logic       want_stop,
  input  logic       nak_rx,
  input  logic [7:0] tx_byte,
  input  logic       sda_in,
  output logic       scl_low,
  output logic       sda_low,
  output logic       busy,
  output logic       dir_rd,
  output logic       ack_stat,
  output logic       in_byte,
  output logic       tx_done,
  output logic       rx_done,
  output logic [7:0] rx_byte
);
  eng_state_e st_q, st_d;
  logic [1:0] q_q, q_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic rd_q, rd_d, scl_q, scl_d, sda_q, sda_d;
  logic busy_q, busy_d, dir_q, dir_d, ack_q, ack_d;
  logic run, tick;

  assign run = (st_q == ENG_START) || (st_q == ENG_BYTE) || (st_q == ENG_STOP);

  i2cm_qtick #(.QDIV(QDIV)) u_qtick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .qtick (tick)
  );

  always_comb begin
    st_d = st_q;   q_d = q_q;     bit_d = bit_q; sh_d = sh_q;
    rd_d = rd_q;   scl_d = scl_q; sda_d = sda_q;
    busy_d = busy_q; dir_d = dir_q; ack_d = ack_q;
    tx_done = 1'b0;  rx_done = 1'b0;
    if (tick) q_d = q_q + 2'd1;
    unique case (st_q)
      ENG_IDLE, ENG_HOLD: begin
        if (go && (want_start || st_q == ENG_HOLD)) begin
          sh_d  = tx_byte;
          bit_d = '0;
          if (want_start) begin
            st_d   = ENG_START;
            busy_d = 1'b1;
            dir_d  = tx_byte[0];
            rd_d   = 1'b0;
          end else begin
            st_d = ENG_BYTE;
            rd_d = dir_q;
          end
        end
      end
      ENG_START: if (tick) begin
        unique case (q_q)
          2'd0: sda_d = 1'b0;
          2'd1: scl_d = 1'b0;
          2'd2: sda_d = 1'b1;
          2'd3: begin scl_d = 1'b1; st_d = ENG_BYTE; end
        endcase
      end
      ENG_BYTE: if (tick) begin
        unique case (q_q)
          2'd0: sda_d = bit_q[3] ? (rd_q && !nak_rx) : (!rd_q && !sh_q[7]);
          2'd1: scl_d = 1'b0;
          2'd2: begin
            if (bit_q[3])  ack_d = rd_q ? nak_rx : sda_in;
            else if (rd_q) sh_d  = {sh_q[6:0], sda_in};
          end
          2'd3: begin
            scl_d = 1'b1;
            if (bit_q[3]) begin
              tx_done = !rd_q;
              rx_done = rd_q;
              st_d    = want_stop ? ENG_STOP : ENG_HOLD;
            end else begin
              bit_d = bit_q + 4'd1;
              if (!rd_q) sh_d = {sh_q[6:0], 1'b0};
            end
          end
        endcase
      end
      ENG_STOP: if (tick) begin
        unique case (q_q)
          2'd0: sda_d = 1'b1;
          2'd1: scl_d = 1'b0;
          2'd2: sda_d = 1'b0;
          2'd3: begin busy_d = 1'b0; st_d = ENG_IDLE; end
        endcase
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ENG_IDLE; q_q <= '0; bit_q <= '0; sh_q <= '0;
      rd_q <= 1'b0; scl_q <= 1'b0; sda_q <= 1'b0;
      busy_q <= 1'b0; dir_q <= 1'b0; ack_q <= 1'b0;
    end else begin
      st_q <= st_d; q_q <= q_d; bit_q <= bit_d; sh_q <= sh_d;
      rd_q <= rd_d; scl_q <= scl_d; sda_q <= sda_d;
      busy_q <= busy_d; dir_q <= dir_d; ack_q <= ack_d;
    end
  end

  assign scl_low  = scl_q;
  assign sda_low  = sda_q;
  assign busy     = busy_q;
  assign dir_rd   = dir_q;
  assign ack_stat = ack_q;
  assign in_byte  = (st_q == ENG_BYTE);
  assign rx_byte  = sh_q;
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              stat_we,
  input  logic [1:0]        stat_wdata,
  input  logic              buf_we,
  input  logic [7:0]        buf_wdata,
  input  logic              tx_done,
  input  logic              rx_done,
  input  logic [7:0]        rx_byte,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              txe_q,
  output logic              rxf_q,
  output logic [7:0]        buf_q
);
  logic [CTRL_W-1:0] ctrl_d;
  logic              txe_d, rxf_d;
  logic [7:0]        buf_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = ctrl_wdata;
    if (tx_done || rx_done) ctrl_d[CB_TB] = 1'b0;

    txe_d = txe_q && !(stat_we && stat_wdata[0]);
    rxf_d = rxf_q && !(stat_we && stat_wdata[1]);
    if (tx_done) txe_d = 1'b1;
    if (rx_done) rxf_d = 1'b1;

    buf_d = buf_q;
    if (buf_we)  buf_d = buf_wdata;
    if (rx_done) buf_d = rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      txe_q  <= 1'b0;
      rxf_q  <= 1'b0;
      buf_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      txe_q  <= txe_d;
      rxf_q  <= rxf_d;
      buf_q  <= buf_d;
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int QDIV = 312
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              stat_we,
  input  logic [1:0]        stat_wdata,
  input  logic              buf_we,
  input  logic [7:0]        buf_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [7:0]        buf_q,
  output logic              tx_empty,
  output logic              rx_full,
  output logic              busy,
  output logic              dir_rd,
  output logic              ack_stat,
  output logic              irq,
  output logic              scl_low,
  output logic              sda_low,
  input  logic              sda_in
);
  logic [1:0] rs_q;
  logic       rst_ns;
  logic       eng_tx_done, eng_rx_done, eng_in_byte;
  logic [7:0] eng_rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  i2cm_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_ns),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .stat_we    (stat_we),
    .stat_wdata (stat_wdata),
    .buf_we     (buf_we),
    .buf_wdata  (buf_wdata),
    .tx_done    (eng_tx_done),
    .rx_done    (eng_rx_done),
    .rx_byte    (eng_rx_byte),
    .ctrl_q     (ctrl_q),
    .txe_q      (tx_empty),
    .rxf_q      (rx_full),
    .buf_q      (buf_q)
  );

  i2cm_engine #(.QDIV(QDIV)) u_eng (
    .clk        (clk),
    .rst_n      (rst_ns),
    .go         (ctrl_q[CB_TB]),
    .want_start (ctrl_q[CB_START]),
    .want_stop  (ctrl_q[CB_STOP]),
    .nak_rx     (ctrl_q[CB_ACKNAK]),
    .tx_byte    (buf_q),
    .sda_in     (sda_in),
    .scl_low    (scl_low),
    .sda_low    (sda_low),
    .busy       (busy),
    .dir_rd     (dir_rd),
    .ack_stat   (ack_stat),
    .in_byte    (eng_in_byte),
    .tx_done    (eng_tx_done),
    .rx_done    (eng_rx_done),
    .rx_byte    (eng_rx_byte)
  );

  assign irq = tx_empty | rx_full;
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
  import i2cm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              scl_low,
  input logic              sda_low,
  input logic              in_byte,
  input logic              busy,
  input logic              tx_empty,
  input logic              rx_full,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              stat_we,
  input logic [1:0]        stat_wdata
);
  // R1: lines are released whenever the bus is not owned
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_low && !sda_low));

  // R3: a transmit completion always retires the trigger
  p_tb_retired_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty) |-> !ctrl_q[CB_TB]);

  // R4: a zero in the clear mask keeps the flag
  p_w1c_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && !stat_wdata[0] && tx_empty) |=> tx_empty);

  // R5: a byte ending without stop leaves the bus owned
  p_hold_owned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_empty) && !ctrl_q[CB_STOP]) |-> busy);

  // R7: a receive completion always retires the trigger
  p_rx_retired_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> !ctrl_q[CB_TB]);

  // R9: no SDA change while SCL is high inside a byte
  p_sda_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_byte && $past(in_byte) && !scl_low && !$past(scl_low)) |-> $stable(sda_low));
endmodule

bind i2c_byte_master i2cm_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_low    (scl_low),
  .sda_low    (sda_low),
  .in_byte    (eng_in_byte),
  .busy       (busy),
  .tx_empty   (tx_empty),
  .rx_full    (rx_full),
  .ctrl_q     (ctrl_q),
  .stat_we    (stat_we),
  .stat_wdata (stat_wdata)
);

// File: tb/sim_i2c_byte_master.sv
`timescale 1ns/1ps
module sim_i2c_byte_master;
  logic clk = 1'b0;
  logic rst_n;
  logic ctrl_we, stat_we, buf_we;
  logic [4:0] ctrl_wdata;
  logic [1:0] stat_wdata;
  logic [7:0] buf_wdata;
  logic [4:0] ctrl_q;
  logic [7:0] buf_q;
  logic tx_empty, rx_full, busy, dir_rd, ack_stat, irq, scl_low, sda_low;
  logic sl_low;
  wire  scl = !scl_low;
  wire  sda = !(sda_low | sl_low);

  int checks = 0, errors = 0;

  always #4 clk = !clk;

  i2c_byte_master #(.QDIV(4)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .stat_we(stat_we), .stat_wdata(stat_wdata),
    .buf_we(buf_we), .buf_wdata(buf_wdata),
    .ctrl_q(ctrl_q), .buf_q(buf_q),
    .tx_empty(tx_empty), .rx_full(rx_full), .busy(busy), .dir_rd(dir_rd),
    .ack_stat(ack_stat), .irq(irq), .scl_low(scl_low), .sda_low(sda_low),
    .sda_in(sda)
  );

  // ---------------- slave model ----------------
  logic mon_en, p_scl, p_sda, addr_ph, reading, ack_en, m_ack;
  logic [7:0] rx, cur;
  logic [7:0] got [0:7];
  logic [7:0] rdq [0:3];
  int bitcnt, ngot, ri, starts, stops, hi_edges;

  always @(scl or sda) begin
    if (mon_en) begin
      if (scl !== p_scl) begin
        if (scl === 1'b1) begin
          if (bitcnt < 8) rx = {rx[6:0], sda};
          else if (bitcnt == 8 && reading && !sl_low) begin
            m_ack = sda;
            if (sda) reading = 1'b0;
          end
          bitcnt++;
        end else begin
          if (bitcnt == 8) begin
            if (addr_ph) begin
              reading = rx[0]; addr_ph = 1'b0; got[ngot] = rx; ngot++; sl_low = ack_en;
            end else if (!reading) begin
              got[ngot] = rx; ngot++; sl_low = ack_en;
            end else sl_low = 1'b0;
          end else if (bitcnt == 9) begin
            bitcnt = 0;
            if (reading) begin cur = rdq[ri]; ri++; sl_low = !cur[7]; end
            else sl_low = 1'b0;
          end else if (reading && !addr_ph && bitcnt >= 1 && bitcnt <= 7)
            sl_low = !cur[7-bitcnt];
        end
      end else if (sda !== p_sda && scl === 1'b1) begin
        hi_edges++;
        if (sda === 1'b0) begin starts++; bitcnt = 0; addr_ph = 1'b1; reading = 1'b0; end
        else stops++;
      end
    end
    p_scl = scl;
    p_sda = sda;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [4:0] v);
    ctrl_wdata = v; ctrl_we = 1'b1; @(negedge clk); ctrl_we = 1'b0;
  endtask
  task automatic wr_buf(input logic [7:0] v);
    buf_wdata = v; buf_we = 1'b1; @(negedge clk); buf_we = 1'b0;
  endtask
  task automatic clr_stat(input logic [1:0] m);
    stat_wdata = m; stat_we = 1'b1; @(negedge clk); stat_we = 1'b0;
  endtask
  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 3000) begin @(negedge clk); n++; end
    chk(req, "irq raised", irq, 1);
  endtask
  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 3000) begin @(negedge clk); n++; end
    chk(req, "busy fell", busy, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1", "ctrl_q", ctrl_q, 0);
    chk("R1", "flags", {tx_empty, rx_full, irq}, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "lines", {scl_low, sda_low}, 0);
  endtask

  task automatic t_addr_write();
    wr_buf(8'hA0);
    wr_ctrl(5'h09);                      // start + trigger
    wait_irq("R3");
    chk("R2", "start seen", starts, 1);
    chk("R2", "address byte", got[0], 8'hA0);
    chk("R2", "direction", dir_rd, 0);
    chk("R3", "tx_empty", tx_empty, 1);
    chk("R3", "trigger cleared", ctrl_q, 5'h01);
    chk("R3", "ack status", ack_stat, 0);
    chk("R5", "busy held", busy, 1);
    clr_stat(2'b10);
    chk("R4", "zero bit keeps tx_empty", tx_empty, 1);
    clr_stat(2'b01);
    chk("R4", "one bit clears tx_empty", {tx_empty, irq}, 0);
  endtask

  task automatic t_data_collide();
    int n = 0;
    wr_buf(8'h3C);
    stat_wdata = 2'b01; stat_we = 1'b1;  // clear held across the whole byte
    wr_ctrl(5'h18);
    while (!tx_empty && n < 3000) begin @(negedge clk); n++; end
    stat_we = 1'b0;
    chk("R10", "set beats clear", tx_empty, 1);
    @(negedge clk);
    chk("R10", "flag retained", tx_empty, 1);
    clr_stat(2'b01);
  endtask

  task automatic t_data_plain();
    wr_buf(8'hC5);
    wr_ctrl(5'h18);
    wait_irq("R5");
    chk("R5", "data bytes MSB first", {got[1], got[2]}, 16'h3CC5);
    chk("R5", "no stop", stops, 0);
    chk("R5", "SCL held low", scl_low, 1);
    chk("R11", "enable retained", ctrl_q, 5'h10);
    clr_stat(2'b01);
  endtask

  task automatic t_rep_start();
    rdq[0] = 8'h96; rdq[1] = 8'h5A; ri = 0;
    wr_buf(8'hA1);
    wr_ctrl(5'h09);
    wait_irq("R6");
    chk("R6", "repeated start", starts, 2);
    chk("R6", "no stop before it", stops, 0);
    chk("R6", "read address", got[3], 8'hA1);
    chk("R2", "direction read", dir_rd, 1);
    clr_stat(2'b01);
  endtask

  task automatic t_read_ack();
    wr_ctrl(5'h18);
    wait_irq("R7");
    chk("R7", "rx_full", {rx_full, tx_empty}, 2'b10);
    chk("R7", "byte in buffer", buf_q, 8'h96);
    chk("R7", "master ACK low", m_ack, 0);
    chk("R7", "trigger cleared", ctrl_q[3], 0);
    clr_stat(2'b10);
    chk("R4", "rx_full cleared", rx_full, 0);
  endtask

  task automatic t_read_nak_stop();
    wr_ctrl(5'h1E);
    wait_irq("R8");
    chk("R8", "byte in buffer", buf_q, 8'h5A);
    chk("R8", "nak status", ack_stat, 1);
    chk("R8", "busy during stop", busy, 1);
    wait_idle("R8");
    chk("R8", "stop seen", stops, 1);
    chk("R8", "master NAK", m_ack, 1);
    chk("R8", "lines released", {scl_low, sda_low}, 0);
    clr_stat(2'b10);
    wr_ctrl(5'h00);
  endtask

  task automatic t_addr_nak();
    ack_en = 1'b0;
    wr_buf(8'hB0);
    wr_ctrl(5'h0B);
    wait_irq("R3");
    chk("R3", "slave NAK status", ack_stat, 1);
    wait_idle("R3");
    chk("R3", "stop after nak", stops, 2);
    chk("R3", "address seen", got[4], 8'hB0);
    clr_stat(2'b01);
    ack_en = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; ctrl_we = 0; stat_we = 0; buf_we = 0;
    ctrl_wdata = '0; stat_wdata = '0; buf_wdata = '0;
    sl_low = 1'b0; mon_en = 1'b0; addr_ph = 0; reading = 0; ack_en = 1'b1; m_ack = 0;
    rx = '0; cur = '0; bitcnt = 0; ngot = 0; ri = 0; starts = 0; stops = 0; hi_edges = 0;
    p_scl = 1'b1; p_sda = 1'b1;
    for (int i = 0; i < 8; i++) got[i] = '0;
    for (int i = 0; i < 4; i++) rdq[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_en = 1'b1;
    t_reset();
    t_addr_write();
    t_data_collide();
    t_data_plain();
    t_rep_start();
    t_read_ack();
    t_read_nak_stop();
    t_addr_nak();
    // R9: only start, repeated start and stop move SDA while SCL is high
    chk("R9", "SDA edges while SCL high", hi_edges, 5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule